// File: doc/BRIEF.md
# Masked Condition Flag Unit

This unit produces a full set of branch conditions from the outcome of each ALU operation and keeps them side by side in a single 12-bit condition register. Every condition is formed from the ALU result, carry and overflow seen in the same cycle as the operation. The register captures the set on the clock edge that closes that cycle, provided the flag-write enable is high.

A branch tests the register by presenting a 12-bit select mask and a one-bit combine mode. In "all" mode the branch is taken only when every selected condition is true. In "any" mode a single true selected condition is enough. Because several bits can be selected together, one branch can test a compound condition such as "not equal and unsigned greater". The decision is combinational from the stored register. A branch issued in the cycle after a flag-writing operation therefore already sees that operation's conditions.

The block has no sequencing states. It has two operating situations, writing (flag-write high) and holding (flag-write low), and the decision logic is active in both.

Top module: `cond_flag_unit`

## Requirements
- R1: While synchronous reset is high, the condition register loads all zeros at each clock edge. With an all-zero register the decision is 0 for every mask and mode.
- R2: On a rising edge with flag-write high, the register captures the conditions computed from the ALU inputs of that same cycle. Carry = 1 means no borrow, so for a compare of a − b it means a ≥ b unsigned.
- R3: On a rising edge with flag-write low, the register keeps its value whatever the ALU inputs do.
- R4: After any write, bit 0 (zero) and bit 1 (not zero) are complements. So are bit 2 (carry) and bit 3 (no carry), and bit 4 (negative, result MSB) and bit 5 (non-negative). Bit 11 (always) is 1.
- R5: Bit 6 holds overflow. Bit 7 (signed greater) is 1 when the result is non-zero and negative equals overflow. Bit 8 (signed less) is 1 when negative differs from overflow. For a compare these match a > b and a < b signed.
- R6: Bit 9 (unsigned greater) is 1 when carry is 1 and the result is non-zero. Bit 10 (unsigned less) is 1 when carry is 0.
- R7: Combine mode 0 ("all") gives a decision of 1 only when the mask is non-zero and every masked register bit is 1.
- R8: Combine mode 1 ("any") gives a decision of 1 when at least one masked register bit is 1.
- R9: An all-zero mask gives a decision of 0 in both modes.
- R10: The decision follows the stored register and the current mask and mode with no register in between. A branch in the cycle after a write sees the new conditions, and a change of mask changes the decision in the same cycle.
- R11: A reset asserted after conditions have been stored clears the register at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| alu_res | input | DATA_W | Result of the current ALU operation |
| alu_carry | input | 1 | Carry out, 1 = no borrow |
| alu_ovf | input | 1 | Signed overflow of the operation |
| flag_we | input | 1 | Store the computed conditions at this edge |
| sel_mask | input | 12 | Selects the conditions a branch tests |
| comb_mode | input | 1 | 0 = all selected true, 1 = any selected true |
| cond_q | output | 12 | Stored condition register |
| take | output | 1 | Branch decision |

## Verification
The hardest situation to reach is a signed overflow that turns the sign bit upside down. Without it, the signed-less condition cannot be told apart from a plain copy of the negative bit. The stimulus compares the most negative value against a small positive one (0x80 minus 0x01). That gives a positive result with overflow set, so a correct unit reports signed-less while negative is 0. A second subtle case is the decision in the cycle right after a write. The bench sets the mask before the writing edge and samples the decision on both sides of that edge.

// File: rtl/cfu_pkg.sv
package cfu_pkg;
    localparam int NUM_COND = 12;

    localparam int C_ZERO  = 0;
    localparam int C_NZERO = 1;
    localparam int C_CARRY = 2;
    localparam int C_NCARY = 3;
    localparam int C_NEG   = 4;
    localparam int C_NNEG  = 5;
    localparam int C_OVF   = 6;
    localparam int C_SGT   = 7;
    localparam int C_SLT   = 8;
    localparam int C_UGT   = 9;
    localparam int C_ULT   = 10;
    localparam int C_ALWAYS = 11;

    typedef enum logic {
        COMB_ALL = 1'b0,
        COMB_ANY = 1'b1
    } comb_mode_t;
endpackage

// File: rtl/cfu_eval.sv
module cfu_eval
    import cfu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0]   res,
    input  logic                carry,
    input  logic                ovf,
    output logic [NUM_COND-1:0] cond_d
);
    localparam int MSB = DATA_W - 1;

    logic is_zero;
    logic is_neg;

    always_comb begin
        is_zero = (res == '0);
        is_neg  = res[MSB];
        cond_d            = '0;
        cond_d[C_ZERO]    = is_zero;
        cond_d[C_NZERO]   = !is_zero;
        cond_d[C_CARRY]   = carry;
        cond_d[C_NCARY]   = !carry;
        cond_d[C_NEG]     = is_neg;
        cond_d[C_NNEG]    = !is_neg;
        cond_d[C_OVF]     = ovf;
        cond_d[C_SGT]     = !is_zero && (is_neg == ovf);
        cond_d[C_SLT]     = is_neg != ovf;
        cond_d[C_UGT]     = carry && !is_zero;
        cond_d[C_ULT]     = !carry;
        cond_d[C_ALWAYS]  = 1'b1;
    end
endmodule

// File: rtl/cfu_store.sv
module cfu_store
    import cfu_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  logic [NUM_COND-1:0] d,
    output logic [NUM_COND-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (we) begin
            q <= d;
        end
    end

    // R3
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(q));

    // R4
    zero_pair_chk: assert property (@(posedge clk) disable iff (rst)
        we |=> (q[C_ZERO] != q[C_NZERO]));

    // R4
    always_bit_chk: assert property (@(posedge clk) disable iff (rst)
        we |=> q[C_ALWAYS]);

    // R5
    signed_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(q[C_SGT] && q[C_SLT]));
endmodule

// File: rtl/cfu_pick.sv
module cfu_pick
    import cfu_pkg::*;
(
    input  logic [NUM_COND-1:0] cond,
    input  logic [NUM_COND-1:0] mask,
    input  comb_mode_t          mode,
    output logic                take
);
    logic [NUM_COND-1:0] hit;
    logic [NUM_COND-1:0] need;

    always_comb begin
        hit  = cond & mask;
        need = ~mask | cond;
        unique case (mode)
            COMB_ALL: take = (|mask) && (&need);
            COMB_ANY: take = |hit;
        endcase
    end
endmodule

// File: rtl/cond_flag_unit.sv
module cond_flag_unit
    import cfu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [DATA_W-1:0]   alu_res,
    input  logic                alu_carry,
    input  logic                alu_ovf,
    input  logic                flag_we,
    input  logic [11:0]         sel_mask,
    input  logic                comb_mode,
    output logic [11:0]         cond_q,
    output logic                take
);
    logic [NUM_COND-1:0] cond_d;
    comb_mode_t          mode_e;

    assign mode_e = comb_mode_t'(comb_mode);

    cfu_eval #(.DATA_W(DATA_W)) u_eval (
        .res    (alu_res),
        .carry  (alu_carry),
        .ovf    (alu_ovf),
        .cond_d (cond_d)
    );

    cfu_store u_store (
        .clk (clk),
        .rst (rst),
        .we  (flag_we),
        .d   (cond_d),
        .q   (cond_q)
    );

    cfu_pick u_pick (
        .cond (cond_q),
        .mask (sel_mask),
        .mode (mode_e),
        .take (take)
    );

    // R9
    empty_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_mask == '0) |-> !take);

    // R8
    any_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (comb_mode && ((cond_q & sel_mask) != '0)) |-> take);

    // R7
    all_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (!comb_mode && take) |-> ((cond_q & sel_mask) == sel_mask));

    // R2
    neg_capture_chk: assert property (@(posedge clk) disable iff (rst)
        flag_we |=> (cond_q[C_NEG] == $past(alu_res[DATA_W-1])));
endmodule

// File: tb/test_cond_flag_unit.sv
module test_cond_flag_unit;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [DW-1:0] alu_res = '0;
    logic          alu_carry = 1'b0;
    logic          alu_ovf = 1'b0;
    logic          flag_we = 1'b0;
    logic [11:0]   sel_mask = '0;
    logic          comb_mode = 1'b0;
    logic [11:0]   cond_q;
    logic          take;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cond_flag_unit #(.DATA_W(DW)) i_cond_flag_unit (
        .clk(clk), .rst(rst), .alu_res(alu_res), .alu_carry(alu_carry),
        .alu_ovf(alu_ovf), .flag_we(flag_we), .sel_mask(sel_mask),
        .comb_mode(comb_mode), .cond_q(cond_q), .take(take)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] expect_vec(input logic [DW-1:0] a, input logic [DW-1:0] b);
        logic [DW-1:0] r;
        logic [11:0] v;
        r = a - b;
        v[0]  = (a == b);
        v[1]  = (a != b);
        v[2]  = (a >= b);
        v[3]  = (a < b);
        v[4]  = r[DW-1];
        v[5]  = !r[DW-1];
        v[6]  = (a[DW-1] != b[DW-1]) && (r[DW-1] != a[DW-1]);
        v[7]  = $signed(a) > $signed(b);
        v[8]  = $signed(a) < $signed(b);
        v[9]  = a > b;
        v[10] = a < b;
        v[11] = 1'b1;
        return v;
    endfunction

    // drive a compare a-b with flag-write for one edge; return just after the edge
    task automatic do_cmp(input logic [DW-1:0] a, input logic [DW-1:0] b);
        logic [DW-1:0] r;
        r = a - b;
        @(negedge clk);
        alu_res   = r;
        alu_carry = (a >= b);
        alu_ovf   = (a[DW-1] != b[DW-1]) && (r[DW-1] != a[DW-1]);
        flag_we   = 1'b1;
        @(negedge clk);
        flag_we   = 1'b0;
        #1;
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        sel_mask = 12'hFFF; comb_mode = 1'b1;
        #1;
        chk("R1 reg", cond_q, 12'h000);
        chk("R1 take", take, 1'b0);
        rst = 1'b0;
    endtask

    task automatic t_equal;
        do_cmp(8'd5, 8'd5);
        chk("R2 eq vec", cond_q, expect_vec(8'd5, 8'd5));
        chk("R4 zero pair", {cond_q[1], cond_q[0]}, 2'b01);
        chk("R4 always", cond_q[11], 1'b1);
    endtask

    task automatic t_signed;
        do_cmp(8'h03, 8'hFE);
        chk("R5 sgt/slt", {cond_q[8], cond_q[7]}, 2'b01);
        chk("R6 ugt/ult", {cond_q[10], cond_q[9]}, 2'b10);
        do_cmp(8'h80, 8'h01);
        chk("R5 overflow vec", cond_q, expect_vec(8'h80, 8'h01));
        chk("R5 slt on ovf", {cond_q[8], cond_q[6], cond_q[4]}, 3'b110);
    endtask

    task automatic t_hold;
        logic [11:0] keep;
        do_cmp(8'd9, 8'd2);
        keep = cond_q;
        chk("R6 9>2 vec", cond_q, expect_vec(8'd9, 8'd2));
        @(negedge clk);
        alu_res = 8'h00; alu_carry = 1'b0; alu_ovf = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        chk("R3 hold", cond_q, keep);
    endtask

    task automatic t_and;
        comb_mode = 1'b0;
        sel_mask = 12'h202; #1;
        chk("R7 all true", take, 1'b1);
        sel_mask = 12'h003; #1;
        chk("R7 one false", take, 1'b0);
    endtask

    task automatic t_or;
        comb_mode = 1'b1;
        sel_mask = 12'h201; #1;
        chk("R8 one true", take, 1'b1);
        sel_mask = 12'h101; #1;
        chk("R8 none true", take, 1'b0);
    endtask

    task automatic t_zero_mask;
        sel_mask = 12'h000;
        comb_mode = 1'b0; #1;
        chk("R9 all mode", take, 1'b0);
        comb_mode = 1'b1; #1;
        chk("R9 any mode", take, 1'b0);
    endtask

    task automatic t_next_cycle;
        @(negedge clk);
        sel_mask = 12'h001; comb_mode = 1'b1;
        alu_res = 8'h00; alu_carry = 1'b1; alu_ovf = 1'b0; flag_we = 1'b1;
        #1;
        chk("R10 before edge", take, 1'b0);
        @(negedge clk);
        flag_we = 1'b0;
        #1;
        chk("R10 after edge", take, 1'b1);
    endtask

    task automatic t_mid_reset;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R11 cleared", cond_q, 12'h000);
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_equal();
        t_signed();
        t_hold();
        t_and();
        t_or();
        t_zero_mask();
        t_next_cycle();
        t_mid_reset();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule